// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Framer

The framer sits after a fetch stage that delivers instruction text as a stream of 16-bit parcels over a valid/ready handshake. It looks at the length prefix in the low bits of the first parcel of each instruction. From that prefix it works out how many parcels the instruction occupies: one, two, three, four, or five plus a 4-bit count. It gathers that many parcels and presents the whole instruction as one wide word, together with its parcel count. Short and long instructions may follow one another in any mix, and no mode setting is involved.

A first parcel whose count field holds the reserved value is not framed. The block emits a single output beat that carries a reserved flag, drops that one parcel, and treats the next parcel as the start of a new instruction. A completed instruction stays on the output until the downstream side accepts it, and the input stalls for that time. A synchronous flush discards any partly gathered instruction.

Top module: `parcel_framer`

## Requirements
- R1: A first parcel whose bits [1:0] are not 2'b11 is a complete instruction, reported with `outLen` = 1.
- R2: A first parcel with bits [1:0] = 2'b11 and bits [4:2] not 3'b111 starts an instruction of 2 parcels (`outLen` = 2).
- R3: A first parcel with bits [4:0] all ones and bit 5 = 0 starts an instruction of 3 parcels (`outLen` = 3).
- R4: A first parcel with bits [5:0] all ones and bit 6 = 0 starts an instruction of 4 parcels (`outLen` = 4).
- R5: A first parcel with bits [6:0] all ones and count n = bits [10:7] below 15 starts an instruction of 5+n parcels (`outLen` = 5+n, at most 19).
- R6: A first parcel with bits [6:0] all ones and bits [10:7] = 4'b1111 produces one output beat with `outReserved` = 1, `outLen` = 0 and `outData` = 0. That parcel is dropped, and the next parcel starts a new instruction.
- R7: In a framed instruction, parcel k (k = 0 for the first) appears at `outData[16k+15:16k]`. All bits above parcel `outLen`-1 are zero.
- R8: While `outValid` = 1 and `outReady` = 0, `inReady` is 0 and `outData`, `outLen` and `outReserved` hold. A beat is consumed only when both are high. No parcel is lost or duplicated, and a new parcel may enter in the same cycle as an output beat is accepted.
- R9: A cycle with `flush` = 1 holds `inReady` low. It discards any partly gathered instruction and any held output beat, and framing restarts at the next accepted parcel.
- R10: After reset, `outValid` = 0 and `inReady` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Input parcel is valid |
| inReady | output | 1 | Block accepts a parcel this cycle |
| inParcel | input | 16 | Instruction parcel |
| flush | input | 1 | Synchronous discard of framing state |
| outValid | output | 1 | Output beat is valid |
| outReady | input | 1 | Downstream accepts the beat |
| outData | output | 304 | Assembled instruction, first parcel in the lowest bits |
| outLen | output | 5 | Parcel count of the instruction, 0 for a reserved beat |
| outReserved | output | 1 | Beat reports a reserved length encoding |

## Verification
A wrong parcel count or a bad index for where a parcel is written does not stay local to one instruction. Every later boundary shifts, so the next output beat carries the wrong length or parcels from two instructions mixed together, and it fails against the model at once. A stall that does not hold, or a flush that leaves stale state, shows as a lost, duplicated or misaligned beat within the instruction that follows. The random stream mixes all length classes with random valid gaps and random backpressure, so such faults show up within a few beats.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int PARCEL_W  = 16;
  localparam int CNT_W     = 4;
  localparam int LONG_BASE = 5;
  localparam int MAX_PARCELS = LONG_BASE + (2**CNT_W - 2);
  localparam int OUT_W     = PARCEL_W * MAX_PARCELS;
  localparam int LEN_W     = $clog2(MAX_PARCELS + 1);

  typedef logic [LEN_W-1:0]    lenT;
  typedef logic [PARCEL_W-1:0] parcelT;

  typedef struct packed {
    logic clear;
    logic write;
    lenT  idx;
  } strobeT;
endpackage

// File: rtl/framer_lendec.sv
module framer_lendec
  import framer_pkg::*;
(
  input  parcelT head,
  output lenT    decLen,
  output logic   decRes
);
  logic [CNT_W-1:0] extCnt;
  assign extCnt = head[7 +: CNT_W];

  always_comb begin
    decRes = 1'b0;
    if (head[1:0] != 2'b11)       decLen = LEN_W'(1);
    else if (head[4:2] != 3'b111) decLen = LEN_W'(2);
    else if (!head[5])            decLen = LEN_W'(3);
    else if (!head[6])            decLen = LEN_W'(4);
    else if (extCnt == '1) begin
      decLen = '0;
      decRes = 1'b1;
    end else begin
      decLen = LEN_W'(LONG_BASE) + LEN_W'(extCnt);
    end
  end
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   outReady,
  input  logic   flush,
  input  lenT    decLen,
  input  logic   decRes,
  output logic   inReady,
  output logic   outValid,
  output logic   outReserved,
  output lenT    outLen,
  output strobeT stb
);
  lenT  count, need, lenQ;
  logic validQ, resQ;
  logic inFire, outFire, atStart;

  assign inReady  = !flush && (!validQ || outReady);
  assign inFire   = inValid && inReady;
  assign outFire  = validQ && outReady;
  assign atStart  = (count == '0);

  assign stb.clear = outFire || flush;
  assign stb.write = inFire && !(atStart && decRes);
  assign stb.idx   = count;

  assign outValid    = validQ;
  assign outReserved = resQ;
  assign outLen      = lenQ;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      count  <= '0;
      need   <= '0;
      lenQ   <= '0;
      validQ <= 1'b0;
      resQ   <= 1'b0;
    end else begin
      if (outFire) begin
        validQ <= 1'b0;
        resQ   <= 1'b0;
        lenQ   <= '0;
      end
      if (inFire) begin
        if (atStart) begin
          if (decRes) begin
            validQ <= 1'b1;
            resQ   <= 1'b1;
            lenQ   <= '0;
          end else if (decLen == LEN_W'(1)) begin
            validQ <= 1'b1;
            lenQ   <= decLen;
          end else begin
            count <= LEN_W'(1);
            need  <= decLen;
          end
        end else if (count + LEN_W'(1) == need) begin
          validQ <= 1'b1;
          lenQ   <= need;
          count  <= '0;
        end else begin
          count <= count + LEN_W'(1);
        end
      end
    end
  end

  a_r8_stall: assert property (@(posedge clk) disable iff (!rstN)
    validQ && !outReady |-> !inReady);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    validQ && !outReady && !flush |=> validQ && $stable(lenQ) && $stable(resQ));
  a_r6_res_len: assert property (@(posedge clk) disable iff (!rstN)
    resQ |-> validQ && lenQ == '0);
  a_r5_len_range: assert property (@(posedge clk) disable iff (!rstN)
    validQ && !resQ |-> lenQ >= LEN_W'(1) && lenQ <= LEN_W'(MAX_PARCELS));
  a_r9_flush: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !validQ && count == '0);
  a_r8_idle_count: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> count == '0);
endmodule

// File: rtl/framer_datapath.sv
module framer_datapath
  import framer_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  parcelT         inParcel,
  input  strobeT         stb,
  output logic [OUT_W-1:0] outData
);
  for (genvar i = 0; i < MAX_PARCELS; i++) begin : g_slot
    parcelT slot;
    always_ff @(posedge clk) begin
      if (!rstN)                                   slot <= '0;
      else if (stb.write && stb.idx == LEN_W'(i))  slot <= inParcel;
      else if (stb.clear)                          slot <= '0;
    end
    assign outData[i*PARCEL_W +: PARCEL_W] = slot;

    a_r7_slot_load: assert property (@(posedge clk) disable iff (!rstN)
      stb.write && stb.idx == LEN_W'(i) |=> slot == $past(inParcel));
  end
endmodule

// File: rtl/parcel_framer.sv
module parcel_framer
  import framer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [15:0]      inParcel,
  input  logic             flush,
  output logic             outValid,
  input  logic             outReady,
  output logic [303:0]     outData,
  output logic [4:0]       outLen,
  output logic             outReserved
);
  lenT    decLen;
  logic   decRes;
  strobeT stb;

  framer_lendec u_dec (
    .head   (inParcel),
    .decLen (decLen),
    .decRes (decRes)
  );

  framer_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .outReady    (outReady),
    .flush       (flush),
    .decLen      (decLen),
    .decRes      (decRes),
    .inReady     (inReady),
    .outValid    (outValid),
    .outReserved (outReserved),
    .outLen      (outLen),
    .stb         (stb)
  );

  framer_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inParcel (inParcel),
    .stb      (stb),
    .outData  (outData)
  );

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReserved |-> (outData >> (int'(outLen) * PARCEL_W)) == '0);
  a_r6_res_data: assert property (@(posedge clk) disable iff (!rstN)
    outReserved |-> outData == '0);
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !flush |=> $stable(outData));
endmodule

// File: tb/parcel_framer_test.sv
`timescale 1ns/1ps
module parcel_framer_test;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid, inReady, flush, outValid, outReady, outReserved;
  logic [15:0]  inParcel;
  logic [303:0] outData;
  logic [4:0]   outLen;

  int checks = 0;
  int errors = 0;

  logic [15:0]  parcQ[$];
  logic [303:0] expData[$];
  int           expLen[$];
  bit           expRes[$];
  string        expTag[$];

  always #2 clk = ~clk;

  parcel_framer uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inParcel(inParcel), .flush(flush), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLen(outLen),
    .outReserved(outReserved)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [303:0] act, input logic [303:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // cls: 0..3 short classes, 4 long with count n, 5 reserved
  task automatic addInstr(input int cls, input int n);
    logic [15:0]  p;
    logic [303:0] d;
    int           len;
    string        tag;
    p = 16'($urandom);
    case (cls)
      0: begin p[1:0] = 2'($urandom % 3); len = 1; tag = "R1"; end
      1: begin p[1:0] = 2'b11; p[4:2] = 3'($urandom % 7); len = 2; tag = "R2"; end
      2: begin p[4:0] = 5'h1f; p[5] = 1'b0; len = 3; tag = "R3"; end
      3: begin p[5:0] = 6'h3f; p[6] = 1'b0; len = 4; tag = "R4"; end
      4: begin p[6:0] = 7'h7f; p[10:7] = 4'(n); len = 5 + n; tag = "R5"; end
      default: begin p[6:0] = 7'h7f; p[10:7] = 4'hf; len = 0; tag = "R6"; end
    endcase
    d = '0;
    parcQ.push_back(p);
    if (len > 0) d[15:0] = p;
    for (int k = 1; k < len; k++) begin
      logic [15:0] q;
      q = 16'($urandom);
      parcQ.push_back(q);
      d[k*16 +: 16] = q;
    end
    expData.push_back(d);
    expLen.push_back(len);
    expRes.push_back(cls == 5);
    expTag.push_back(tag);
  endtask

  task automatic step(input bit v, input logic [15:0] p, input bit rdy,
                      input bit fl, output bit inF);
    @(negedge clk);
    inValid = v; inParcel = p; outReady = rdy; flush = fl;
    #1;
    inF = v && inReady;
    if (outValid && rdy && !fl) begin
      if (expLen.size() == 0) begin
        chk(1'b0, "R8 unexpected beat", 304'(outLen), 304'(0));
      end else begin
        string t;
        t = expTag.pop_front();
        chk(int'(outLen) == expLen[0], {t, " length"}, 304'(outLen), 304'(expLen[0]));
        chk(outReserved == expRes[0], {t, " reserved flag"}, 304'(outReserved), 304'(expRes[0]));
        chk(outData == expData[0], {t, "/R7 data"}, outData, expData[0]);
        void'(expLen.pop_front());
        void'(expRes.pop_front());
        void'(expData.pop_front());
      end
    end
  endtask

  task automatic runStream(input bit randomize_hs);
    int guard = 0;
    while ((parcQ.size() > 0 || expLen.size() > 0) && guard < 60000) begin
      bit v, r, f;
      v = parcQ.size() > 0 && (!randomize_hs || ($urandom % 4 != 0));
      r = !randomize_hs || ($urandom % 3 != 0);
      step(v, v ? parcQ[0] : 16'h0, r, 1'b0, f);
      if (f) void'(parcQ.pop_front());
      guard++;
    end
    chk(parcQ.size() == 0 && expLen.size() == 0, "R8 stream drained",
        304'(parcQ.size() + expLen.size()), 304'(0));
  endtask

  initial begin
    #720000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit f;
    logic [303:0] held;
    void'($urandom(32'd20251));
    rstN = 1'b0; inValid = 1'b0; inParcel = '0; flush = 1'b0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(outValid == 1'b0, "R10 valid in reset", 304'(outValid), 304'(0));
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(outValid == 1'b0, "R10 valid after reset", 304'(outValid), 304'(0));
    chk(inReady == 1'b1, "R10 ready after reset", 304'(inReady), 304'(1));

    // directed: every class, boundary counts, reserved then short
    addInstr(0, 0); addInstr(1, 0); addInstr(2, 0); addInstr(3, 0);
    addInstr(4, 0); addInstr(4, 14); addInstr(5, 0); addInstr(0, 0);
    addInstr(5, 0); addInstr(4, 7);
    runStream(1'b0);

    // R8 backpressure: hold a finished two-parcel instruction
    addInstr(1, 0);
    step(1'b1, parcQ[0], 1'b0, 1'b0, f); void'(parcQ.pop_front());
    step(1'b1, parcQ[0], 1'b0, 1'b0, f); void'(parcQ.pop_front());
    step(1'b1, 16'h0001, 1'b0, 1'b0, f);
    chk(f == 1'b0, "R8 input stalled", 304'(f), 304'(0));
    chk(outValid == 1'b1, "R8 beat held", 304'(outValid), 304'(1));
    held = outData;
    step(1'b1, 16'h0001, 1'b0, 1'b0, f);
    chk(f == 1'b0 && outData == held, "R8 data stable", outData, held);
    runStream(1'b0);

    // R9 flush in the middle of a four-parcel instruction
    step(1'b1, 16'hA53F, 1'b0, 1'b0, f);
    chk(f == 1'b1, "R9 first parcel taken", 304'(f), 304'(1));
    step(1'b1, 16'h1234, 1'b0, 1'b0, f);
    step(1'b1, 16'h5678, 1'b0, 1'b1, f);
    chk(f == 1'b0, "R9 no intake during flush", 304'(f), 304'(0));
    step(1'b0, 16'h0, 1'b0, 1'b0, f);
    chk(outValid == 1'b0 && inReady == 1'b1, "R9 idle after flush",
        304'({outValid, inReady}), 304'(2'b01));
    addInstr(0, 0); addInstr(2, 0);
    runStream(1'b0);

    // constrained random mix with random gaps and backpressure
    for (int i = 0; i < 600; i++) begin
      int c;
      c = int'($urandom % 12);
      if (c < 4)       addInstr(0, 0);
      else if (c < 6)  addInstr(1, 0);
      else if (c < 7)  addInstr(2, 0);
      else if (c < 8)  addInstr(3, 0);
      else if (c < 11) addInstr(4, int'($urandom % 15));
      else             addInstr(5, 0);
    end
    runStream(1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule